// File: doc/BRIEF.md
# Fail-safe clock monitor with switchover

This block guards a device against the loss of its external clock. An always-running internal reference clock, which is also the block's own clock, is divided down to a slow sample clock. Each sample period arms a "waiting" flag when the sample clock rises. Any falling edge of the monitored clock discharges that flag. If the flag is still armed when the sample clock falls, then half a sample period has passed with no activity on the monitored clock, and a failure is declared.

On a failure the block does three things. It sets a sticky interrupt flag. It forces the effective clock selection to the internal source. It pulses a reset to the watchdog so that watchdog timing restarts at the switchover. The software-visible selection value keeps whatever software last wrote to it. A separate fail-safe state drives the forced selection. That state is cleared by reset or by a new selection write, and monitoring resumes at the next rising edge of the sample clock.

The monitored clock's falling edges are turned into a toggle that crosses into the reference domain through a two-stage synchronizer. All flag and compare logic runs on the reference clock. The block cannot detect a failure of the reference clock itself.

Top module: `clk_failsafe_mon`

## Requirements
- R1: The divider counts reference cycles 0 to 63 (DIV_LOG2 = 6), starting from 0 after reset. The sample clock rises on the edge after count 31 and falls on the edge after count 63.
- R2: A falling edge of the monitored clock takes effect three reference rising edges after it happens. The first reference edge after the monitored edge is counted as edge 1, and the edge takes effect at edge 3.
- R3: The waiting flag is armed at the sample rising edge. A monitored edge that takes effect while the flag is armed discharges it. A failure is declared at the edge after count 63 if the flag is still armed at that edge, no monitored edge takes effect there, the enable is high, no selection write is present, and the block is not already in fail-safe.
- R4: fail_irq goes to 1 on the edge that declares a failure and stays at 1 until irq_clr is high at a clock edge. A failure declared on the same edge as a clear leaves fail_irq at 1.
- R5: While the fail-safe state is set, clk_src_eff reads 2'b10 (internal). Otherwise clk_src_eff equals sel_status. The selection codes are 00 for primary, 01 for secondary, and 10 or 11 for internal.
- R6: sel_status changes only on an edge with sel_wr high, and it then takes the value of sel_wdata. A failure never changes sel_status.
- R7: wdt_rst is high for exactly one cycle after each declared failure. Further failures are not declared while the block stays in fail-safe.
- R8: While mon_enable is low, no failure is declared and the waiting flag is held disarmed. fail_irq and the fail-safe state keep their values.
- R9: A selection write clears the fail-safe state, disarms the waiting flag and suppresses a failure on the same edge. Monitoring starts again at the next sample rising edge.
- R10: During synchronous reset (rst_n low), fail_irq, wdt_rst and the fail-safe state are 0 and sel_status is 00.
- R11: A monitored clock whose period is well inside a half sample period never causes a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock; clocks all state except the edge toggle |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_clk | input | 1 | Monitored external clock |
| mon_enable | input | 1 | Configuration enable for monitoring |
| irq_clr | input | 1 | Write-one-to-clear for fail_irq |
| sel_wr | input | 1 | Software writes a new clock selection |
| sel_wdata | input | 2 | Selection value written with sel_wr |
| sel_status | output | 2 | Software-visible selection, never altered by failure |
| clk_src_eff | output | 2 | Effective selection sent to the clock multiplexer |
| fail_irq | output | 1 | Sticky oscillator-fail interrupt flag |
| wdt_rst | output | 1 | One-cycle watchdog and postscaler reset pulse |

## Verification
The in-design properties assume three things about the inputs. Control inputs change only away from the reference edge and are synchronous to it. The monitored clock toggles no faster than once per reference cycle. The monitored clock keeps running through a reset long enough to clear the edge toggle. The bench meets these conditions by driving every input just after a reference falling edge. It derives the monitored clock from a counter of whole reference cycles with a half-period of at least one cycle. It holds a fast monitored clock during every reset. Within those limits, the stimulus stops and restarts the clock, uses periods that straddle the half-sample window, and places writes and clears next to failure edges.

// File: rtl/cfm_pkg.sv
// Package: shared constants for the fail-safe clock monitor.
// Assumes a two-bit selection code; the top bit set means the internal source.
package cfm_pkg;
    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SRC_PRIMARY   = 2'b00;
    localparam logic [SEL_W-1:0] SRC_SECONDARY = 2'b01;
    localparam logic [SEL_W-1:0] SRC_INTERNAL  = 2'b10;
endpackage

// File: rtl/cfm_edge_sync.sv
// Edge transfer: turns each falling edge of the monitored clock into a
// one-cycle pulse in the reference domain (toggle + SYNC_STAGES flops).
// Assumes the monitored clock toggles no faster than the reference clock and
// runs during reset long enough to clear the toggle.
module cfm_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic edge_seen
);
    logic                   tog;
    logic [SYNC_STAGES-1:0] chain;
    logic                   hist;

    // Flip the toggle on every monitored falling edge.
    always_ff @(negedge mon_clk) begin
        if (!rst_n) tog <= 1'b0;
        else        tog <= ~tog;
    end

    // Resynchronise the toggle into the reference domain, one flop per stage.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge ref_clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= tog;
            end
        end else begin : g_next
            always_ff @(posedge ref_clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    // Keep the previous synchronised level for change detection.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[SYNC_STAGES-1];
    end

    assign edge_seen = chain[SYNC_STAGES-1] ^ hist;

    assert_pulse_single_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        edge_seen |=> !edge_seen);
endmodule

// File: rtl/cfm_sample_div.sv
// Sample divider: free-running counter over 2**DIV_LOG2 reference cycles,
// decoded into sample-clock rising and falling events.
// Assumes DIV_LOG2 >= 2.
module cfm_sample_div #(
    parameter int DIV_LOG2 = 6
) (
    input  logic ref_clk,
    input  logic rst_n,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int DIV  = 1 << DIV_LOG2;
    localparam int HALF = DIV / 2;
    localparam logic [DIV_LOG2-1:0] RISE_AT = DIV_LOG2'(HALF - 1);
    localparam logic [DIV_LOG2-1:0] FALL_AT = DIV_LOG2'(DIV - 1);

    logic [DIV_LOG2-1:0] cnt;

    // Advance the divider every reference cycle.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign rise_evt = (cnt == RISE_AT);
    assign fall_evt = (cnt == FALL_AT);

    assert_events_exclusive_R1: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fall_evt |=> !fall_evt && !rise_evt);
endmodule

// File: rtl/cfm_detect.sv
// Failure detector: holds the waiting flag, declares failures and drives the
// sticky interrupt and the watchdog reset pulse.
// Assumes rise_evt and fall_evt never occur in the same cycle.
module cfm_detect (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_enable,
    input  logic edge_seen,
    input  logic rise_evt,
    input  logic fall_evt,
    input  logic sel_wr,
    input  logic irq_clr,
    input  logic failsafe,
    output logic fail_evt,
    output logic fail_irq,
    output logic wdt_rst
);
    logic armed;

    assign fail_evt = mon_enable && fall_evt && armed && !edge_seen
                      && !failsafe && !sel_wr;

    // Arm at sample rise; drop on a monitored edge, sample fall, disable or write.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                      armed <= 1'b0;
        else if (!mon_enable || sel_wr)  armed <= 1'b0;
        else if (rise_evt)               armed <= 1'b1;
        else if (fall_evt || edge_seen)  armed <= 1'b0;
    end

    // Sticky interrupt flag; a new failure wins over a same-cycle clear.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)        fail_irq <= 1'b0;
        else if (fail_evt) fail_irq <= 1'b1;
        else if (irq_clr)  fail_irq <= 1'b0;
    end

    // One-cycle watchdog reset after each declared failure.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) wdt_rst <= 1'b0;
        else        wdt_rst <= fail_evt;
    end

    assert_armed_by_rise_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(armed) |-> $past(rise_evt));
    assert_irq_sticky_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        fail_irq && !irq_clr |=> fail_irq);
    assert_irq_with_pulse_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_rst |-> fail_irq);
    assert_quiet_when_off_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !mon_enable |=> !wdt_rst);
endmodule

// File: rtl/cfm_select.sv
// Selection control: keeps the software-visible selection and the separate
// fail-safe state, and forms the effective selection.
// Assumes a write and a failure are never both taken (detector suppresses).
module cfm_select
    import cfm_pkg::*;
(
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             fail_evt,
    output logic             failsafe,
    output logic [SEL_W-1:0] sel_status,
    output logic [SEL_W-1:0] clk_src_eff
);
    // Software-written selection; untouched by failures.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)      sel_status <= SRC_PRIMARY;
        else if (sel_wr) sel_status <= sel_wdata;
    end

    // Fail-safe state: set by a failure, cleared by a new write.
    always_ff @(posedge ref_clk) begin
        if (!rst_n)        failsafe <= 1'b0;
        else if (sel_wr)   failsafe <= 1'b0;
        else if (fail_evt) failsafe <= 1'b1;
    end

    // Effective selection handed to the clock multiplexer.
    always_comb begin
        clk_src_eff = failsafe ? SRC_INTERNAL : sel_status;
    end

    assert_status_hold_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !sel_wr |=> $stable(sel_status));
    assert_write_clears_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        sel_wr |=> !failsafe);
endmodule

// File: rtl/clk_failsafe_mon.sv
// Top: fail-safe clock monitor. Watches mon_clk with a divided reference,
// forces the internal source and pulses the watchdog reset on failure.
// Assumes ref_clk is always running and control inputs are ref_clk-synchronous.
module clk_failsafe_mon
    import cfm_pkg::*;
#(
    parameter int DIV_LOG2    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic             mon_enable,
    input  logic             irq_clr,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_wdata,
    output logic [SEL_W-1:0] sel_status,
    output logic [SEL_W-1:0] clk_src_eff,
    output logic             fail_irq,
    output logic             wdt_rst
);
    logic edge_seen, rise_evt, fall_evt, fail_evt, failsafe;

    cfm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mon_clk  (mon_clk),
        .edge_seen(edge_seen)
    );

    cfm_sample_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt)
    );

    cfm_detect u_det (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .mon_enable(mon_enable),
        .edge_seen (edge_seen),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .sel_wr    (sel_wr),
        .irq_clr   (irq_clr),
        .failsafe  (failsafe),
        .fail_evt  (fail_evt),
        .fail_irq  (fail_irq),
        .wdt_rst   (wdt_rst)
    );

    cfm_select u_sel (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .fail_evt   (fail_evt),
        .failsafe   (failsafe),
        .sel_status (sel_status),
        .clk_src_eff(clk_src_eff)
    );

    assert_detect_on_fall_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_rst |-> $past(fall_evt));
    assert_forced_internal_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_rst |-> clk_src_eff == SRC_INTERNAL);
    assert_single_pulse_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);
endmodule

// File: tb/clk_failsafe_mon_test.sv
`timescale 1ns/100ps
module clk_failsafe_mon_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_clk = 1'b1;
    logic       mon_enable = 1'b0;
    logic       irq_clr = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic [1:0] sel_status, clk_src_eff;
    logic       fail_irq, wdt_rst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int mon_half = 2;   // 0 = monitored clock stopped
    int mon_cnt  = 0;
    int pulses   = 0;
    int irq_at_pulse = 0;
    bit mvalid = 0;
    bit done = 0;

    // behavioural reference model state
    int m_cnt = 0;
    bit m_armed = 0, m_fs = 0, m_irq = 0, m_wdt = 0;
    int m_status = 0;
    int q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    clk_failsafe_mon uut (
        .ref_clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .mon_enable(mon_enable),
        .irq_clr(irq_clr), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .sel_status(sel_status), .clk_src_eff(clk_src_eff),
        .fail_irq(fail_irq), .wdt_rst(wdt_rst)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Reference model: advances on each reference rising edge.
    always @(posedge clk) begin
        bit seen, rise, fall, fail;
        cyc = cyc + 1;
        if (!rst_n) begin
            m_cnt = 0; m_armed = 0; m_fs = 0; m_irq = 0; m_wdt = 0; m_status = 0;
            q.delete();
            mvalid = 1;
        end else begin
            seen = 0;
            while (q.size() > 0 && q[0] <= cyc) begin
                if (q[0] == cyc) seen = 1;
                void'(q.pop_front());
            end
            rise = (m_cnt == 31);
            fall = (m_cnt == 63);
            fail = mon_enable && fall && m_armed && !seen && !m_fs && !sel_wr;
            m_wdt = fail;
            if (fail) m_irq = 1; else if (irq_clr) m_irq = 0;
            if (sel_wr) m_fs = 0; else if (fail) m_fs = 1;
            if (sel_wr) m_status = sel_wdata;
            if (!mon_enable || sel_wr) m_armed = 0;
            else if (rise) m_armed = 1;
            else if (fall || seen) m_armed = 0;
            m_cnt = (m_cnt + 1) % 64;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (mvalid && !done) begin
            chk(wdt_rst == m_wdt, "R7 (timing R1 R2 R3)", "wdt_rst", wdt_rst, m_wdt);
            chk(fail_irq == m_irq, "R4", "fail_irq", fail_irq, m_irq);
            chk(sel_status == m_status[1:0], "R6", "sel_status", sel_status, m_status);
            chk(clk_src_eff == (m_fs ? 2'b10 : m_status[1:0]), "R5", "clk_src_eff",
                clk_src_eff, m_fs ? 2 : m_status);
            if (wdt_rst) begin
                pulses++;
                if (fail_irq) irq_at_pulse++;
            end
        end
    end

    // Monitored clock generator, 1 ns after each reference falling edge.
    always @(negedge clk) begin
        #1.0;
        if (mon_half > 0) begin
            mon_cnt++;
            if (mon_cnt >= mon_half) begin
                mon_cnt = 0;
                mon_clk = ~mon_clk;
                if (!mon_clk && rst_n) q.push_back(cyc + 3);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #0.5;
            sel_wr = 1'b0;
        end
    endtask

    task automatic do_reset();
        mon_half = 2;
        @(negedge clk); #0.5;
        rst_n = 1'b0;
        step(8);
        // R10: reset state while reset is held
        chk(fail_irq == 0, "R10", "fail_irq in reset", fail_irq, 0);
        chk(wdt_rst == 0, "R10", "wdt_rst in reset", wdt_rst, 0);
        chk(sel_status == 0, "R10", "sel_status in reset", sel_status, 0);
        chk(clk_src_eff == 0, "R10", "clk_src_eff in reset", clk_src_eff, 0);
        rst_n = 1'b1;
    endtask

    task automatic write_sel(input logic [1:0] v);
        @(negedge clk); #0.5;
        sel_wr = 1'b1; sel_wdata = v;
        step(1);
    endtask

    initial begin
        int p0;
        do_reset();
        mon_enable = 1'b1;

        // R11: healthy clocks at two rates
        mon_half = 3;  step(300);
        chk(fail_irq == 0, "R11", "irq with period 6", fail_irq, 0);
        mon_half = 10; step(300);
        chk(fail_irq == 0, "R11", "irq with period 20", fail_irq, 0);

        // R3 R5 R6 R7: stop the clock
        p0 = pulses;
        mon_half = 0; step(200);
        chk(fail_irq == 1, "R3", "irq after stop", fail_irq, 1);
        chk(clk_src_eff == 2'b10, "R5", "forced internal", clk_src_eff, 2);
        chk(sel_status == 2'b00, "R6", "status kept", sel_status, 0);
        chk(pulses - p0 == 1, "R7", "single pulse while failed", pulses - p0, 1);

        // R4: clear while still in fail-safe
        @(negedge clk); #0.5; irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        step(150);
        chk(fail_irq == 0, "R4", "irq after clear", fail_irq, 0);

        // R9: new selection restores it
        mon_half = 4;
        write_sel(2'b01);
        step(2);
        chk(clk_src_eff == 2'b01, "R9", "eff after write", clk_src_eff, 1);
        step(200);
        chk(fail_irq == 0, "R9", "no fail after restart", fail_irq, 0);

        // R4: failure beats a clear held high
        p0 = irq_at_pulse;
        irq_clr = 1'b1; mon_half = 0; step(200); irq_clr = 1'b0;
        chk(irq_at_pulse - p0 == 1, "R4", "irq set despite clear", irq_at_pulse - p0, 1);

        // R8: disabled, stopped clock, fail-safe cleared
        mon_enable = 1'b0;
        write_sel(2'b00);
        @(negedge clk); #0.5; irq_clr = 1'b1; step(1); irq_clr = 1'b0;
        step(300);
        chk(fail_irq == 0, "R8", "no fail while disabled", fail_irq, 0);
        chk(clk_src_eff == 2'b00, "R8", "eff while disabled", clk_src_eff, 0);

        // R9: frequent writes keep re-disarming the window
        mon_enable = 1'b1;
        for (int k = 0; k < 15; k++) begin
            write_sel(2'b11);
            step(19);
        end
        chk(fail_irq == 0, "R9", "writes suppress failure", fail_irq, 0);
        step(200);
        chk(fail_irq == 1, "R3", "fail once writes stop", fail_irq, 1);

        // R1 R2: slow clocks around the window edge, checked by the model
        write_sel(2'b00);
        mon_half = 20; step(600);
        write_sel(2'b01);
        mon_half = 35; step(600);
        write_sel(2'b00);
        mon_half = 14; step(400);

        // R10: mid-run reset
        do_reset();
        step(2);
        chk(fail_irq == 0, "R10", "irq after reset", fail_irq, 0);
        chk(sel_status == 0, "R10", "status after reset", sel_status, 0);
        mon_half = 5; step(200);
        chk(fail_irq == 0, "R11", "healthy after reset", fail_irq, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule